// File: doc/BRIEF.md
# Split-Edge Instruction Fetch Stage

This block is the first stage of a 64-bit pipeline. It holds the program counter and the instruction store, and it is built so that one clock cycle covers both the PC update and the instruction read. The PC register loads on the falling clock edge. The instruction store is read on the next rising edge, using the low nine PC bits as a word address. As a result, the word for a new PC comes out half a cycle after that PC appears.

Two decode helpers are computed from the fetched word without a register. The first is a 16-bit field for the control unit, built from three separate bit groups of the instruction. The second is a 5-bit source-register address, taken from one of two instruction bit ranges under a select input. The full 64-bit PC is also driven out for later stages. A preload write port fills the instruction store before a program runs.

Top module: `fetch_stage`

## Requirements
- R1: While `rst` is high, each falling edge clears `pc` to zero and each rising edge clears `instr` to zero. The reset is synchronous and active high. It takes priority over `pc_we`.
- R2: On a falling edge with `rst` low and `pc_we` high, `pc` takes all 64 bits of `pc_next`.
- R3: On a falling edge with `rst` low and `pc_we` low, `pc` keeps its value whatever `pc_next` holds.
- R4: `pc` changes only on falling edges. The value set at a falling edge is still present after the following rising edge.
- R5: On each rising edge with `rst` low, `instr` takes the store word at address `pc[8:0]`. PC bits 63:9 have no effect, so PC 0x200 fetches word 0 and PC 0x1FF fetches word 511.
- R6: On a rising edge with `pre_we` high, `pre_data` is written to word `pre_addr`. A read of that same word on that same edge returns the old contents.
- R7: `ctrl_field` is `{instr[28:23], instr[17:16], instr[7:0]}`, with bit 15 as the most significant bit.
- R8: `rs1_addr` is `instr[17:13]` when `rs1_sel` is 0 and `instr[22:18]` when `rs1_sel` is 1. It follows `rs1_sel` without waiting for a clock edge.
- R9: `instr` changes only on rising edges. It keeps its value through the falling edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; PC loads on the falling edge, store is read on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_next | input | 64 | Next program counter value |
| pc_we | input | 1 | PC load enable; low stalls the PC |
| rs1_sel | input | 1 | Source-register range select: 0 picks bits 17:13, 1 picks bits 22:18 |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 9 | Preload word address |
| pre_data | input | 32 | Preload word |
| pc | output | 64 | Current program counter |
| instr | output | 32 | Fetched instruction word |
| ctrl_field | output | 16 | Packed field for the control unit |
| rs1_addr | output | 5 | Selected source-register address |

## Verification
The bench loads PC values whose upper bits are nonzero and runs through addresses 0x1FF and 0x200. A design that decoded more than nine address bits, or that dropped PC bits on the way out, would fetch the wrong word or report a wrong PC.

The bench also drives `pc_next` with new values while the enable is low. A stall that leaked through would move the PC. A reset in mid-run is included as well; if reset lost to the enable, the PC would not return to zero.

A preload is made while the PC points at a different word, and that word is then fetched, so an ignored write would return stale data. Every fetched word is checked against the expected control field and source address for both select values. A reversed select, or a bit group placed out of order, would therefore show up.

// File: rtl/fetch_pkg.sv
`timescale 1ns/1ps
package fetch_pkg;
    typedef enum logic {
        RS1_FROM_LOW  = 1'b0,
        RS1_FROM_HIGH = 1'b1
    } rs1_src_e;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [4:0]  rs1;
    } decode_fields_t;
endpackage

// File: rtl/pc_unit.sv
`timescale 1ns/1ps
module pc_unit #(
    parameter int PC_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pc_we,
    input  logic [PC_W-1:0] pc_next,
    output logic [PC_W-1:0] pc_q
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.pc = '0;
        end else if (pc_we) begin
            state_d.pc = pc_next;
        end
    end

    // The PC register is clocked on the falling edge.
    always_ff @(negedge clk) begin
        state_q <= state_d;
    end

    assign pc_q = state_q.pc;
endmodule

// File: rtl/instr_store.sv
`timescale 1ns/1ps
module instr_store #(
    parameter int DEPTH  = 512,
    parameter int WORD_W = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
    } rd_state_t;

    logic [WORD_W-1:0] mem [DEPTH];
    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rst) begin
            rd_d.word = '0;
        end else begin
            rd_d.word = mem[rd_addr];
        end
    end

    // Read and preload share the rising edge. A read of the word being
    // written on the same edge returns the old contents.
    always_ff @(posedge clk) begin
        rd_q <= rd_d;
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = rd_q.word;
endmodule

// File: rtl/field_extract.sv
`timescale 1ns/1ps
module field_extract
    import fetch_pkg::*;
(
    input  logic [5:0]     grp_hi,
    input  logic [1:0]     grp_mid,
    input  logic [7:0]     grp_lo,
    input  logic [4:0]     src_low,
    input  logic [4:0]     src_high,
    input  rs1_src_e       src_sel,
    output decode_fields_t fields
);
    always_comb begin
        fields.ctrl = {grp_hi, grp_mid, grp_lo};
        unique case (src_sel)
            RS1_FROM_HIGH: fields.rs1 = src_high;
            default:       fields.rs1 = src_low;
        endcase
    end
endmodule

// File: rtl/fetch_stage.sv
`timescale 1ns/1ps
module fetch_stage
    import fetch_pkg::*;
#(
    parameter int PC_W   = 64,
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   pc_next,
    input  logic              pc_we,
    input  logic              rs1_sel,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [31:0]       pre_data,
    output logic [PC_W-1:0]   pc,
    output logic [31:0]       instr,
    output logic [15:0]       ctrl_field,
    output logic [4:0]        rs1_addr
);
    decode_fields_t fields;

    pc_unit #(.PC_W(PC_W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .pc_we   (pc_we),
        .pc_next (pc_next),
        .pc_q    (pc)
    );

    instr_store #(.DEPTH(DEPTH), .WORD_W(32)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (pc[ADDR_W-1:0]),
        .wr_en   (pre_we),
        .wr_addr (pre_addr),
        .wr_data (pre_data),
        .rd_data (instr)
    );

    field_extract u_fields (
        .grp_hi   (instr[28:23]),
        .grp_mid  (instr[17:16]),
        .grp_lo   (instr[7:0]),
        .src_low  (instr[17:13]),
        .src_high (instr[22:18]),
        .src_sel  (rs1_src_e'(rs1_sel)),
        .fields   (fields)
    );

    assign ctrl_field = fields.ctrl;
    assign rs1_addr   = fields.rs1;
endmodule

// File: rtl/fetch_stage_chk.sv
`timescale 1ns/1ps
module fetch_stage_chk #(
    parameter int PC_W = 64
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] pc_next,
    input logic            pc_we,
    input logic            rs1_sel,
    input logic [PC_W-1:0] pc,
    input logic [31:0]     instr,
    input logic [15:0]     ctrl_field,
    input logic [4:0]      rs1_addr
);
    // R1
    pc_reset_chk: assert property (@(negedge clk) rst |=> pc == '0);

    // R1
    instr_reset_chk: assert property (@(posedge clk) rst |=> instr == '0);

    // R2
    pc_load_chk: assert property (@(negedge clk) disable iff (rst)
        pc_we |=> pc == $past(pc_next));

    // R3
    pc_stall_chk: assert property (@(negedge clk) disable iff (rst)
        !pc_we |=> $stable(pc));

    // R7
    ctrl_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(instr) |-> $stable(ctrl_field));

    // R8
    rs1_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(instr) && $stable(rs1_sel)) |-> $stable(rs1_addr));
endmodule

bind fetch_stage fetch_stage_chk #(.PC_W(PC_W)) u_fetch_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_next    (pc_next),
    .pc_we      (pc_we),
    .rs1_sel    (rs1_sel),
    .pc         (pc),
    .instr      (instr),
    .ctrl_field (ctrl_field),
    .rs1_addr   (rs1_addr)
);

// File: tb/test_fetch_stage.sv
`timescale 1ns/1ps
module test_fetch_stage;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] pc_next = '0;
    logic        pc_we = 1'b0;
    logic        rs1_sel = 1'b0;
    logic        pre_we = 1'b0;
    logic [8:0]  pre_addr = '0;
    logic [31:0] pre_data = '0;
    logic [63:0] pc;
    logic [31:0] instr;
    logic [15:0] ctrl_field;
    logic [4:0]  rs1_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit reported = 0;

    typedef struct {
        int          due;
        logic [63:0] pc;
        logic [31:0] ins;
        logic        sel;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m_mem [512];
    logic [63:0] m_pc = '0;

    fetch_stage i_fetch_stage (
        .clk(clk), .rst(rst), .pc_next(pc_next), .pc_we(pc_we),
        .rs1_sel(rs1_sel), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .pc(pc), .instr(instr),
        .ctrl_field(ctrl_field), .rs1_addr(rs1_addr)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] word_of(int i);
        logic [31:0] v;
        v = 32'(i) * 32'h0101_0F3B;
        return v ^ 32'hA5C3_1E77 ^ (32'(i) << 23);
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: sets inputs half a nanosecond after a rising edge and
    // queues what the ports must show after the next rising edge.
    task automatic step(bit r, bit we, logic [63:0] nxt, bit sel, string req,
                        bit w = 0, logic [8:0] wa = '0, logic [31:0] wd = '0);
        exp_t e;
        @(posedge clk);
        #0.5;
        rst = r; pc_we = we; pc_next = nxt; rs1_sel = sel;
        pre_we = w; pre_addr = wa; pre_data = wd;
        if (r) m_pc = '0;
        else if (we) m_pc = nxt;
        e.due = cyc + 1;
        e.pc  = m_pc;
        e.ins = r ? 32'h0 : m_mem[m_pc[8:0]];
        e.sel = sel;
        e.req = req;
        sb.push_back(e);
        if (w) m_mem[wa] = wd;
    endtask

    // Monitor: compares a quarter nanosecond after each rising edge.
    always @(posedge clk) begin
        #0.25;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            logic [15:0] c;
            logic [4:0]  s;
            e = sb.pop_front();
            c = {e.ins[28:23], e.ins[17:16], e.ins[7:0]};
            s = e.sel ? e.ins[22:18] : e.ins[17:13];
            check(pc === e.pc, e.req, "pc (R4)", pc, e.pc);
            check(instr === e.ins, e.req, "instr (R5/R9)", 64'(instr), 64'(e.ins));
            check(ctrl_field === c, "R7", "ctrl_field", 64'(ctrl_field), 64'(c));
            check(rs1_addr === s, "R8", "rs1_addr", 64'(rs1_addr), 64'(s));
        end
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < 512; i++) m_mem[i] = word_of(i);
        // R6: preload every word while reset is held
        for (int i = 0; i < 512; i++) begin
            @(posedge clk);
            #0.5;
            pre_we = 1'b1; pre_addr = 9'(i); pre_data = m_mem[i];
        end
        @(posedge clk);
        #0.5;
        pre_we = 1'b0;
        @(posedge clk);
        #0.25;
        // R1: reset state
        check(pc === 64'h0, "R1", "pc under reset", pc, 64'h0);
        check(instr === 32'h0, "R1", "instr under reset", 64'(instr), 64'h0);

        // R2/R5/R8: sequential loads with upper PC bits set
        for (int i = 1; i <= 16; i++)
            step(0, 1, 64'hF00D_0000_0000_0000 | 64'(i * 37), i[0], "R2");
        // R3: stall while pc_next moves
        for (int i = 0; i < 4; i++)
            step(0, 0, 64'h1234_5678_0000_0100 + 64'(i), i[0], "R3");
        // R1: reset during run, with priority over the enable
        step(1, 1, 64'h0000_0000_0000_00AA, 0, "R1");
        step(1, 1, 64'h0000_0000_0000_00AB, 1, "R1");
        // R5: address boundaries
        step(0, 1, 64'h0000_0000_0000_01FF, 1, "R5");
        step(0, 1, 64'h0000_0000_0000_0200, 0, "R5");
        step(0, 1, 64'h8000_0000_0000_0203, 1, "R5");
        // R6: write word 7 while the PC sits at 3, then fetch it
        step(0, 1, 64'h0000_0000_0000_0003, 0, "R6", 1, 9'd7, 32'hC0DE_F00D);
        step(0, 1, 64'h0000_0000_0000_0007, 0, "R6");
        step(0, 0, 64'h0000_0000_0000_0009, 1, "R6");
        // R6: same-edge write and read of the current word returns old data
        step(0, 1, 64'h0000_0000_0000_000B, 0, "R6", 1, 9'd11, 32'h1357_9BDF);
        step(0, 0, 64'h0, 1, "R6");
        step(0, 0, 64'h0, 0, "R9");
        repeat (3) @(posedge clk);
        report();
    end
endmodule